// File: doc/BRIEF.md
# Device Address Translation Cache

This block sits between a device's DMA engine and the host's I/O memory management unit. It holds a small set of recently used translations, each keyed by a 20-bit process address space ID and a 36-bit virtual page number, and returns a 28-bit physical page number for every lookup. When the DMA engine presents a (PASID, virtual page) pair that is not cached, the block asks the host for a translation. If the host answers that the page is absent, the block asks for the page to be brought in, waits for the outcome, and then asks for the translation again. Only the answer to a translation request is ever written into the cache.

The host can withdraw a cached translation at any time with an invalidation, which the block acknowledges. An invalidation that targets the page whose miss is being resolved makes the pending answer untrustworthy. That answer is thrown away and the page is translated again. Only one miss is handled at a time, and the lookup port is held not-ready while it is open.

Top module: `dev_xlat_cache`

## Requirements
- R1: After reset the lookup port is ready, and no response, translation request, page request or invalidation acknowledge is asserted.
- R2: A lookup that hits a valid entry whose PASID and virtual page both match is answered in the cycle after acceptance with the cached physical page and the error flag low. No translation request is issued.
- R3: A lookup that misses issues exactly one translation request in the cycle after acceptance, carrying the lookup's PASID and virtual page. The lookup port stays not-ready until the miss has been answered.
- R4: A translation response with the present flag set is reported on the response port in the following cycle with that physical page and the error flag low. It is also written into the cache, so that a repeat lookup of the same pair hits.
- R5: A translation response with the present flag clear causes a page request in the following cycle, carrying the same PASID and virtual page.
- R6: A successful page response causes a new translation request in the following cycle and produces no response on the lookup side. The final answer comes only from that new translation.
- R7: A failed page response ends the lookup in the following cycle with the response valid, the error flag high and a physical page of zero.
- R8: An invalidation clears every valid entry whose PASID and virtual page both equal the invalidation's, so the next lookup of that pair misses. Entries that differ in either field are kept.
- R9: The invalidation acknowledge is a one-cycle pulse exactly two cycles after the invalidation is presented, one cycle after the entry has been cleared.
- R10: An invalidation for the pair whose miss is outstanding, arriving while the block waits for the translation response or in the same cycle as that response, causes the response to be discarded and a new translation request to be issued.
- R11: A lookup presented in the same cycle as an invalidation of the same pair is treated as a miss.
- R12: The cache has 8 fully associative entries filled in strict rotation starting at entry 0. The ninth fill after reset replaces the first filled translation and leaves the other seven.
- R13: Entries with the same virtual page but different PASIDs are distinct. A lookup or invalidation for one PASID neither hits nor clears the other's entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request from the DMA engine |
| lk_ready | output | 1 | Lookup may be accepted this cycle |
| lk_pasid | input | 20 | Requester's address space ID |
| lk_vpn | input | 36 | Virtual page number to translate |
| rsp_valid | output | 1 | One-cycle lookup result pulse |
| rsp_ppn | output | 28 | Physical page number of the result |
| rsp_err | output | 1 | Lookup ended because the page could not be brought in |
| tr_req_valid | output | 1 | One-cycle translation request pulse to the host |
| tr_req_pasid | output | 20 | Address space ID of the translation request |
| tr_req_vpn | output | 36 | Virtual page of the translation request |
| tr_rsp_valid | input | 1 | Translation response from the host |
| tr_rsp_present | input | 1 | Page is present and the physical page is valid |
| tr_rsp_ppn | input | 28 | Translated physical page number |
| pg_req_valid | output | 1 | One-cycle page request pulse to the host |
| pg_req_pasid | output | 20 | Address space ID of the page request |
| pg_req_vpn | output | 36 | Virtual page to be brought in |
| pg_rsp_valid | input | 1 | Page response from the host |
| pg_rsp_ok | input | 1 | Page was brought in successfully |
| inv_valid | input | 1 | Invalidation request from the host |
| inv_pasid | input | 20 | Address space ID to invalidate |
| inv_vpn | input | 36 | Virtual page to invalidate |
| inv_ack | output | 1 | Invalidation acknowledge pulse |

## Verification
Two collisions matter here. An invalidation can land in the same cycle as a lookup of the pair it removes, and it can land while the translation response for that pair is still pending. The bench forks a lookup and an invalidation onto the same clock edge. It also holds back the host's translation response so that an invalidation falls inside the wait. In both cases the host remaps the page when it invalidates, so a stale fill would return the old physical page. The bench therefore judges each collision by the page number returned and by the number of translation requests counted on the host side.

// File: rtl/dev_xlat_pkg.sv
`timescale 1ns/1ps
package dev_xlat_pkg;
    localparam int PASID_W = 20;
    localparam int VPN_W   = 36;
    localparam int PPN_W   = 28;

    typedef struct packed {
        logic [PASID_W-1:0] pasid;
        logic [VPN_W-1:0]   vpn;
    } xtag_t;

    typedef enum logic [2:0] {
        MS_IDLE,
        MS_TREQ,
        MS_TWAIT,
        MS_PREQ,
        MS_PWAIT
    } miss_st_e;
endpackage

// File: rtl/xlat_tag_array.sv
`timescale 1ns/1ps
module xlat_tag_array
    import dev_xlat_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  xtag_t            lk_tag,
    output logic             hit,
    output logic [PPN_W-1:0] hit_ppn,
    input  logic             inv_valid,
    input  xtag_t            inv_tag,
    input  logic             fill_en,
    input  xtag_t            fill_tag,
    input  logic [PPN_W-1:0] fill_ppn
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic [ENTRIES-1:0]            vld;
        xtag_t [ENTRIES-1:0]           tag;
        logic [ENTRIES-1:0][PPN_W-1:0] ppn;
        logic [IDX_W-1:0]              rr;
    } arr_st_t;

    arr_st_t            st_d, st_q;
    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] inv_match;
    logic [ENTRIES-1:0] hit_vec;

    // Per-entry comparators for the lookup and the invalidation keys
    generate
        for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
            assign lk_match[e]  = st_q.vld[e] && (st_q.tag[e] == lk_tag);
            assign inv_match[e] = inv_valid && st_q.vld[e] && (st_q.tag[e] == inv_tag);
        end
    endgenerate

    // An entry being invalidated this cycle no longer counts as a hit
    always_comb begin
        hit_vec = lk_match & ~inv_match;
        hit_ppn = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (hit_vec[e]) hit_ppn = hit_ppn | st_q.ppn[e];
        end
        hit = |hit_vec;
    end

    always_comb begin
        st_d = st_q;
        for (int e = 0; e < ENTRIES; e++) begin
            if (inv_match[e]) st_d.vld[e] = 1'b0;
            if (fill_en && (st_q.rr == IDX_W'(e))) begin
                st_d.vld[e] = 1'b1;
                st_d.tag[e] = fill_tag;
                st_d.ppn[e] = fill_ppn;
            end
        end
        if (fill_en) begin
            if (st_q.rr == IDX_W'(ENTRIES - 1)) st_d.rr = '0;
            else                               st_d.rr = st_q.rr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/xlat_miss_fsm.sv
`timescale 1ns/1ps
module xlat_miss_fsm
    import dev_xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  xtag_t            lk_tag,
    output logic             lk_ready,
    input  logic             hit,
    input  logic [PPN_W-1:0] hit_ppn,
    output logic             rsp_valid,
    output logic [PPN_W-1:0] rsp_ppn,
    output logic             rsp_err,
    output logic             tr_req_valid,
    output logic             pg_req_valid,
    output xtag_t            req_tag,
    input  logic             tr_rsp_valid,
    input  logic             tr_rsp_present,
    input  logic [PPN_W-1:0] tr_rsp_ppn,
    input  logic             pg_rsp_valid,
    input  logic             pg_rsp_ok,
    input  logic             inv_valid,
    input  xtag_t            inv_tag,
    output logic             fill_en,
    output logic [PPN_W-1:0] fill_ppn
);
    typedef struct packed {
        miss_st_e         st;
        xtag_t            tag;
        logic             stale;
        logic             rsp_v;
        logic [PPN_W-1:0] rsp_ppn;
        logic             rsp_err;
    } fsm_st_t;

    fsm_st_t st_d, st_q;
    logic    inv_pend;

    always_comb begin
        st_d          = st_q;
        st_d.rsp_v    = 1'b0;
        st_d.rsp_err  = 1'b0;
        fill_en       = 1'b0;
        fill_ppn      = tr_rsp_ppn;
        inv_pend      = inv_valid && (inv_tag == st_q.tag) && (st_q.st != MS_IDLE);

        unique case (st_q.st)
            MS_IDLE: begin
                if (lk_valid) begin
                    if (hit) begin
                        st_d.rsp_v   = 1'b1;
                        st_d.rsp_ppn = hit_ppn;
                    end else begin
                        st_d.tag = lk_tag;
                        st_d.st  = MS_TREQ;
                    end
                end
            end
            MS_TREQ: st_d.st = MS_TWAIT;
            MS_TWAIT: begin
                if (tr_rsp_valid) begin
                    if (st_q.stale || inv_pend) begin
                        st_d.st = MS_TREQ;
                    end else if (tr_rsp_present) begin
                        fill_en      = 1'b1;
                        st_d.rsp_v   = 1'b1;
                        st_d.rsp_ppn = tr_rsp_ppn;
                        st_d.st      = MS_IDLE;
                    end else begin
                        st_d.st = MS_PREQ;
                    end
                end
            end
            MS_PREQ: st_d.st = MS_PWAIT;
            MS_PWAIT: begin
                if (pg_rsp_valid) begin
                    if (pg_rsp_ok) begin
                        st_d.st = MS_TREQ;
                    end else begin
                        st_d.rsp_v   = 1'b1;
                        st_d.rsp_err = 1'b1;
                        st_d.rsp_ppn = '0;
                        st_d.st      = MS_IDLE;
                    end
                end
            end
            default: st_d.st = MS_IDLE;
        endcase

        // A request sent after the invalidation is fresh; otherwise remember it
        if ((st_d.st == MS_TREQ) || (st_d.st == MS_IDLE)) st_d.stale = 1'b0;
        else                                               st_d.stale = st_q.stale || inv_pend;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.st <= MS_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign lk_ready     = (st_q.st == MS_IDLE);
    assign tr_req_valid = (st_q.st == MS_TREQ);
    assign pg_req_valid = (st_q.st == MS_PREQ);
    assign req_tag      = st_q.tag;
    assign rsp_valid    = st_q.rsp_v;
    assign rsp_ppn      = st_q.rsp_ppn;
    assign rsp_err      = st_q.rsp_err;
endmodule

// File: rtl/dev_xlat_cache.sv
`timescale 1ns/1ps
module dev_xlat_cache
    import dev_xlat_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_valid,
    output logic               lk_ready,
    input  logic [PASID_W-1:0] lk_pasid,
    input  logic [VPN_W-1:0]   lk_vpn,
    output logic               rsp_valid,
    output logic [PPN_W-1:0]   rsp_ppn,
    output logic               rsp_err,
    output logic               tr_req_valid,
    output logic [PASID_W-1:0] tr_req_pasid,
    output logic [VPN_W-1:0]   tr_req_vpn,
    input  logic               tr_rsp_valid,
    input  logic               tr_rsp_present,
    input  logic [PPN_W-1:0]   tr_rsp_ppn,
    output logic               pg_req_valid,
    output logic [PASID_W-1:0] pg_req_pasid,
    output logic [VPN_W-1:0]   pg_req_vpn,
    input  logic               pg_rsp_valid,
    input  logic               pg_rsp_ok,
    input  logic               inv_valid,
    input  logic [PASID_W-1:0] inv_pasid,
    input  logic [VPN_W-1:0]   inv_vpn,
    output logic               inv_ack
);
    typedef struct packed {
        logic inv_dly;
        logic ack;
    } ack_st_t;

    xtag_t            lk_tag, inv_tag, req_tag;
    logic             hit;
    logic [PPN_W-1:0] hit_ppn;
    logic             fill_en;
    logic [PPN_W-1:0] fill_ppn;
    ack_st_t          ack_d, ack_q;

    assign lk_tag  = '{pasid: lk_pasid, vpn: lk_vpn};
    assign inv_tag = '{pasid: inv_pasid, vpn: inv_vpn};

    xlat_tag_array #(.ENTRIES(ENTRIES)) u_arr (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_tag   (lk_tag),
        .hit      (hit),
        .hit_ppn  (hit_ppn),
        .inv_valid(inv_valid),
        .inv_tag  (inv_tag),
        .fill_en  (fill_en),
        .fill_tag (req_tag),
        .fill_ppn (fill_ppn)
    );

    xlat_miss_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .lk_valid      (lk_valid),
        .lk_tag        (lk_tag),
        .lk_ready      (lk_ready),
        .hit           (hit),
        .hit_ppn       (hit_ppn),
        .rsp_valid     (rsp_valid),
        .rsp_ppn       (rsp_ppn),
        .rsp_err       (rsp_err),
        .tr_req_valid  (tr_req_valid),
        .pg_req_valid  (pg_req_valid),
        .req_tag       (req_tag),
        .tr_rsp_valid  (tr_rsp_valid),
        .tr_rsp_present(tr_rsp_present),
        .tr_rsp_ppn    (tr_rsp_ppn),
        .pg_rsp_valid  (pg_rsp_valid),
        .pg_rsp_ok     (pg_rsp_ok),
        .inv_valid     (inv_valid),
        .inv_tag       (inv_tag),
        .fill_en       (fill_en),
        .fill_ppn      (fill_ppn)
    );

    // Entries clear on the edge that samples inv_valid; ack follows one cycle later
    always_comb begin
        ack_d.inv_dly = inv_valid;
        ack_d.ack     = ack_q.inv_dly;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ack_q <= '0;
        else        ack_q <= ack_d;
    end

    assign inv_ack      = ack_q.ack;
    assign tr_req_pasid = req_tag.pasid;
    assign tr_req_vpn   = req_tag.vpn;
    assign pg_req_pasid = req_tag.pasid;
    assign pg_req_vpn   = req_tag.vpn;
endmodule

// File: rtl/dev_xlat_cache_chk.sv
`timescale 1ns/1ps
module dev_xlat_cache_chk
    import dev_xlat_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic               lk_ready,
    input logic [PASID_W-1:0] lk_pasid,
    input logic [VPN_W-1:0]   lk_vpn,
    input logic               rsp_valid,
    input logic [PPN_W-1:0]   rsp_ppn,
    input logic               rsp_err,
    input logic               tr_req_valid,
    input logic [PASID_W-1:0] tr_req_pasid,
    input logic [VPN_W-1:0]   tr_req_vpn,
    input logic               tr_rsp_valid,
    input logic               tr_rsp_present,
    input logic [PPN_W-1:0]   tr_rsp_ppn,
    input logic               pg_req_valid,
    input logic [PASID_W-1:0] pg_req_pasid,
    input logic [VPN_W-1:0]   pg_req_vpn,
    input logic               pg_rsp_valid,
    input logic               pg_rsp_ok,
    input logic               inv_valid,
    input logic [PASID_W-1:0] inv_pasid,
    input logic [VPN_W-1:0]   inv_vpn,
    input logic               inv_ack
);
    assert_busy_while_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tr_req_valid |-> !lk_ready);

    assert_req_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tr_req_valid |=> !tr_req_valid);

    assert_absent_leads_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tr_rsp_valid && !tr_rsp_present && !lk_ready) |=> (pg_req_valid || tr_req_valid));

    assert_page_ok_retranslates_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_rsp_valid && pg_rsp_ok && !lk_ready) |=> (tr_req_valid && !rsp_valid));

    assert_page_fail_errors_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_rsp_valid && !pg_rsp_ok && !lk_ready) |=> (rsp_valid && rsp_err && (rsp_ppn == '0)));

    assert_inv_ack_timing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |=> ##1 inv_ack);
endmodule

bind dev_xlat_cache dev_xlat_cache_chk u_chk (.*);

// File: tb/dev_xlat_cache_tb.sv
`timescale 1ns/1ps
module dev_xlat_cache_tb;
    logic        clk;
    logic        rst_n;
    logic        lk_valid;
    logic        lk_ready;
    logic [19:0] lk_pasid;
    logic [35:0] lk_vpn;
    logic        rsp_valid;
    logic [27:0] rsp_ppn;
    logic        rsp_err;
    logic        tr_req_valid;
    logic [19:0] tr_req_pasid;
    logic [35:0] tr_req_vpn;
    logic        tr_rsp_valid;
    logic        tr_rsp_present;
    logic [27:0] tr_rsp_ppn;
    logic        pg_req_valid;
    logic [19:0] pg_req_pasid;
    logic [35:0] pg_req_vpn;
    logic        pg_rsp_valid;
    logic        pg_rsp_ok;
    logic        inv_valid;
    logic [19:0] inv_pasid;
    logic [35:0] inv_vpn;
    logic        inv_ack;

    dev_xlat_cache u_dut (.*);

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Host-side page model
    int gen[4][16];
    bit present[4][16];
    int tr_delay = 2;
    int pg_delay = 2;
    int tr_seen  = 0;
    int pg_seen  = 0;

    function automatic logic [19:0] pasid_of(int i);
        return {18'h25A5A, 2'(i)};
    endfunction
    function automatic logic [35:0] vpn_of(int j);
        return {32'h9A53_0C00, 4'(j)};
    endfunction
    function automatic logic [27:0] ppn_of(int i, int j, int g);
        return 28'(32'h0400000 + i * 32'h10000 + j * 32'h111 + g * 32'h7);
    endfunction
    function automatic bit is_bad(int i, int j);
        return (i == 3) && (j >= 14);
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst_n && tr_req_valid) tr_seen++;
        if (rst_n && pg_req_valid) pg_seen++;
    end

    // Host model: answers translation and page requests after a delay
    initial begin
        int  tr_cd = 0, pg_cd = 0;
        bit  snap_pres = 0;
        logic [27:0] snap_ppn = '0;
        int  pi = 0, pj = 0;
        bit  exp_pg = 0, exp_tr = 0;
        logic [19:0] exp_pasid = '0;
        logic [35:0] exp_vpn = '0;
        tr_rsp_valid = 0; tr_rsp_present = 0; tr_rsp_ppn = '0;
        pg_rsp_valid = 0; pg_rsp_ok = 0;
        forever begin
            @(negedge clk);
            tr_rsp_valid = 0;
            pg_rsp_valid = 0;
            if (exp_pg) begin
                check(pg_req_valid && pg_req_pasid == exp_pasid && pg_req_vpn == exp_vpn,
                      "R5", {pg_req_valid, pg_req_vpn}, {1'b1, exp_vpn});
                exp_pg = 0;
            end
            if (exp_tr) begin
                check(tr_req_valid && !rsp_valid, "R6", {rsp_valid, tr_req_valid}, 2'b01);
                exp_tr = 0;
            end
            if (tr_cd > 0) begin
                tr_cd--;
                if (tr_cd == 0) begin
                    tr_rsp_valid = 1; tr_rsp_present = snap_pres; tr_rsp_ppn = snap_ppn;
                    if (!snap_pres) begin
                        exp_pg = 1; exp_pasid = pasid_of(pi); exp_vpn = vpn_of(pj);
                    end
                end
            end
            if (pg_cd > 0) begin
                pg_cd--;
                if (pg_cd == 0) begin
                    pg_rsp_valid = 1;
                    pg_rsp_ok = !is_bad(pi, pj);
                    if (pg_rsp_ok) begin
                        present[pi][pj] = 1;
                        exp_tr = 1;
                    end
                end
            end
            if (rst_n && tr_req_valid) begin
                pi = int'(tr_req_pasid[1:0]);
                pj = int'(tr_req_vpn[3:0]);
                snap_pres = present[pi][pj];
                snap_ppn = snap_pres ? ppn_of(pi, pj, gen[pi][pj]) : 28'h0;
                tr_cd = tr_delay;
            end
            if (rst_n && pg_req_valid) pg_cd = pg_delay;
        end
    end

    task automatic do_reset();
        rst_n = 0; lk_valid = 0; inv_valid = 0;
        lk_pasid = '0; lk_vpn = '0; inv_pasid = '0; inv_vpn = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    task automatic do_lookup(input int i, input int j, output bit hit, output bit err,
                             output logic [27:0] ppn, output bit req_ok);
        bit rdy;
        bit got;
        @(negedge clk);
        lk_valid = 1; lk_pasid = pasid_of(i); lk_vpn = vpn_of(j);
        got = 0;
        while (!got) begin
            rdy = lk_ready;
            @(posedge clk);
            if (rdy) got = 1;
            else @(negedge clk);
        end
        @(negedge clk);
        lk_valid = 0;
        hit = 0; req_ok = 1;
        if (rsp_valid) begin
            hit = 1;
        end else begin
            req_ok = tr_req_valid && !lk_ready && tr_req_pasid == pasid_of(i) && tr_req_vpn == vpn_of(j);
            for (int n = 0; n < 400 && !rsp_valid; n++) @(negedge clk);
        end
        err = rsp_err;
        ppn = rsp_ppn;
        if (!rsp_valid) check(0, "R3 no response", 0, 1);
    endtask

    task automatic do_inv(input int i, input int j);
        bit a0, a1;
        @(negedge clk);
        gen[i][j]++;
        inv_valid = 1; inv_pasid = pasid_of(i); inv_vpn = vpn_of(j);
        @(negedge clk);
        inv_valid = 0;
        a0 = inv_ack;
        @(negedge clk);
        a1 = inv_ack;
        check(!a0 && a1, "R9", {a0, a1}, 2'b01);
    endtask

    // Lookup of a page known to be cacheable; checks result against the model
    task automatic look_expect(input int i, input int j, input string req,
                               input int exp_hit, output bit hit);
        bit err, rq;
        logic [27:0] ppn;
        logic [27:0] exp_ppn;
        int t0;
        t0 = tr_seen;
        do_lookup(i, j, hit, err, ppn, rq);
        exp_ppn = is_bad(i, j) && !present[i][j] ? 28'h0 : ppn_of(i, j, gen[i][j]);
        check(ppn == exp_ppn && err == (is_bad(i, j) && !present[i][j]), req, ppn, exp_ppn);
        if (!hit) check(rq, "R3", 0, 1);
        if (hit) check(tr_seen == t0, "R2", tr_seen - t0, 0);
        if (exp_hit >= 0) check(hit == bit'(exp_hit), req, hit, exp_hit);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        bit h;
        int t0;
        void'($urandom(32'd20251));
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 16; j++) begin
                gen[i][j] = 0;
                present[i][j] = (j % 3 == 0);
            end
        for (int j = 0; j < 16; j++) present[2][j] = 1;
        present[0][5] = 1; present[0][6] = 1; present[1][5] = 1;

        do_reset();
        @(negedge clk);
        check(lk_ready && !rsp_valid && !tr_req_valid && !pg_req_valid && !inv_ack, "R1",
              {lk_ready, rsp_valid, tr_req_valid, pg_req_valid, inv_ack}, 5'b10000);

        // R2/R4: fill then hit
        look_expect(0, 5, "R4 fill", 0, h);
        look_expect(0, 5, "R2 hit", 1, h);
        look_expect(0, 6, "R4 fill2", 0, h);
        // R13: same vpn, other pasid misses and is distinct
        look_expect(1, 5, "R13 other pasid", 0, h);
        do_inv(1, 5);
        look_expect(0, 5, "R13 kept after other pasid inv", 1, h);
        // R8: invalidation removes only the matching pair
        do_inv(0, 5);
        look_expect(0, 6, "R8 neighbour kept", 1, h);
        look_expect(0, 5, "R8 removed", 0, h);
        // R5/R6: absent page brought in, then retranslated
        t0 = tr_seen;
        look_expect(1, 4, "R6 after page in", 0, h);
        check(tr_seen - t0 == 2 && pg_seen >= 1, "R6 retranslate count", tr_seen - t0, 2);
        look_expect(1, 4, "R4 hit after page in", 1, h);
        // R7: page cannot be brought in
        look_expect(3, 14, "R7 error", 0, h);
        // R11: lookup and invalidation of same cached pair in one cycle
        look_expect(0, 6, "R11 warm", 1, h);
        t0 = tr_seen;
        fork
            look_expect(0, 6, "R11 same cycle", 0, h);
            do_inv(0, 6);
        join
        check(tr_seen - t0 == 1, "R11 count", tr_seen - t0, 1);
        // R10: invalidation while translation outstanding
        tr_delay = 6;
        t0 = tr_seen;
        fork
            look_expect(1, 9, "R10 stale discarded", 0, h);
            begin repeat (3) @(negedge clk); do_inv(1, 9); end
        join
        check(tr_seen - t0 == 2, "R10 count", tr_seen - t0, 2);
        tr_delay = 2;
        // R12: rotation replacement after reset
        do_reset();
        for (int j = 0; j < 9; j++) look_expect(2, j, "R12 fill", 0, h);
        look_expect(2, 1, "R12 survivor", 1, h);
        look_expect(2, 0, "R12 evicted", 0, h);

        // Random phase
        for (int n = 0; n < 250; n++) begin
            int i, j;
            i = $urandom_range(0, 3);
            j = $urandom_range(0, 15);
            tr_delay = $urandom_range(1, 4);
            pg_delay = $urandom_range(1, 4);
            if ($urandom_range(0, 3) == 0) do_inv(i, j);
            else look_expect(i, j, (is_bad(i, j) && !present[i][j]) ? "R7 rand" : "R4 rand", -1, h);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule